// File: doc/BRIEF.md
# Page Write Buffer and Commit Sequencer

This block sits behind the serial front end of a byte-addressed nonvolatile array of 512 pages of 64 bytes each (32K x 8). It holds the single address counter shared by reads and writes. It also collects incoming write bytes into a one-page staging buffer. On a commit request it pushes the staged bytes into the array through a byte-wide write port, one byte per cycle. A busy flag stays raised for the whole self-timed write cycle. The length of that cycle is a parameter counted in clock cycles.

The protocol layer above the block raises a strobe for each event: an address has been received, a data byte has been received, a read byte has been consumed, a valid stop has ended a write, or a transfer was cut short. Write bytes advance only the in-page offset. Read steps advance the full address. A write-protect level turns a commit into a discard. While busy is high the block ignores every request, so the front end can use busy to decide whether to acknowledge.

Top module: `page_commit_buf`

## Requirements
- R1: After reset, busy_o is 0, addr_o is 0 and mem_we_o is 0.
- R2: The address is a page number in bits [14:6] and a byte offset in bits [5:0]. An idle cycle with addr_load_i high sets addr_o to addr_i on the next cycle.
- R3: An accepted byte strobe stores byte_i at the current offset. It then adds one to the offset only, wrapping 63 to 0, and leaves the page number unchanged.
- R4: A read step with no byte strobe adds one to the whole 15-bit address, wrapping 7FFFh to 0000h.
- R5: 64 bytes loaded from offset 32 land at offsets 32..63 and then 0..31. The counter finishes at offset 32.
- R6: Beyond 64 bytes, each new byte replaces the byte staged earlier at the same offset.
- R7: A commit with staged bytes raises busy_o on the next cycle for exactly WCYC_CYCLES cycles. During the first 64 of those cycles it scans offsets upward. It writes only the staged offsets, one per cycle, at {page of addr_o, offset}. At the end the staging buffer is empty.
- R8: A commit while wp_i is 1 writes nothing, leaves busy_o low and empties the staging buffer.
- R9: A commit with nothing staged writes nothing and leaves busy_o low.
- R10: abort_i empties the staging buffer. A byte strobe or commit in the same cycle is dropped and the address does not advance for it.
- R11: While busy_o is 1, address loads, byte strobes, read steps, commits and aborts have no effect.
- R12: A byte strobe in the same cycle as a commit is staged and included in that commit.
- R13: A byte strobe in the same cycle as an address load is staged at the loaded address. The counter then points one offset past it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_load_i | input | 1 | Load addr_i into the address counter |
| addr_i | input | 15 | Address to load |
| byte_vld_i | input | 1 | Write data byte strobe |
| byte_i | input | 8 | Write data byte |
| rd_step_i | input | 1 | Advance the address after a read byte |
| commit_i | input | 1 | Valid end of write; start the write cycle |
| abort_i | input | 1 | Discard staged bytes |
| wp_i | input | 1 | Write protect level |
| busy_o | output | 1 | Self-timed write cycle in progress |
| addr_o | output | 15 | Current address counter |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | 15 | Array write address |
| mem_data_o | output | 8 | Array write data |

## Verification
Two functions can fall in the same cycle. A byte strobe can arrive in the cycle of the commit, or in the cycle of an address load. The bench provokes both by raising the two strobes on one falling edge. It then reads the write port during the sweep that follows. The collision is judged correct when the extra byte shows up as one more write, at the expected offset and with the expected data, and the counter sits one offset beyond it.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int unsigned ADDR_W_DEF = 15;
  localparam int unsigned OFF_W_DEF  = 6;
  localparam int unsigned DATA_W_DEF = 8;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SWEEP = 2'd1,
    SEQ_HOLD  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pcb_addr_ctr.sv
module pcb_addr_ctr #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned OFF_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              off_inc_i,
  input  logic              full_inc_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned PAGE_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] addr_q, base;

  assign base = load_i ? addr_i : addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else if (off_inc_i)
      addr_q <= {base[ADDR_W-1:OFF_W], base[OFF_W-1:0] + OFF_W'(1)};
    else if (full_inc_i)
      addr_q <= base + ADDR_W'(1);
    else if (load_i)
      addr_q <= addr_i;
  end

  assign addr_o = addr_q;

  logic [PAGE_W-1:0] unused_page;
  assign unused_page = base[ADDR_W-1:OFF_W];
endmodule

// File: rtl/pcb_page_buf.sv
module pcb_page_buf #(
  parameter int unsigned OFF_W  = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [OFF_W-1:0]      wr_off_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic                  clr_i,
  input  logic [OFF_W-1:0]      rd_off_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic [(1<<OFF_W)-1:0] mask_o
);
  localparam int unsigned NB = 1 << OFF_W;

  logic [DATA_W-1:0] mem_q [NB];
  logic [NB-1:0]     mask_q;

  always_ff @(posedge clk_i) begin
    if (wr_i && !clr_i) mem_q[wr_off_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (clr_i) mask_q <= '0;
    else if (wr_i)  mask_q[wr_off_i] <= 1'b1;
  end

  assign rd_data_o = mem_q[rd_off_i];
  assign mask_o    = mask_q;
endmodule

// File: rtl/pcb_commit_seq.sv
module pcb_commit_seq
  import pcb_pkg::*;
#(
  parameter int unsigned ADDR_W      = 15,
  parameter int unsigned OFF_W       = 6,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned WCYC_CYCLES = 250000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [ADDR_W-OFF_W-1:0] page_i,
  input  logic [(1<<OFF_W)-1:0] mask_i,
  input  logic [DATA_W-1:0]     rd_data_i,
  output logic [OFF_W-1:0]      rd_off_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  mem_we_o,
  output logic [ADDR_W-1:0]     mem_addr_o,
  output logic [DATA_W-1:0]     mem_data_o
);
  localparam int unsigned PAGE_W = ADDR_W - OFF_W;
  localparam int unsigned NB     = 1 << OFF_W;
  localparam int unsigned CNT_W  = $clog2(WCYC_CYCLES);

  seq_state_e        st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PAGE_W-1:0] page_q;
  logic              last;

  assign last   = (cnt_q == CNT_W'(WCYC_CYCLES - 1));
  assign done_o = (st_q != SEQ_IDLE) && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SEQ_IDLE;
      cnt_q  <= '0;
      page_q <= '0;
    end else begin
      unique case (st_q)
        SEQ_IDLE: if (start_i) begin
          st_q   <= SEQ_SWEEP;
          cnt_q  <= '0;
          page_q <= page_i;
        end
        SEQ_SWEEP: begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(NB - 1)) st_q <= SEQ_HOLD;
        end
        SEQ_HOLD: begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (last) st_q <= SEQ_IDLE;
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign rd_off_o   = cnt_q[OFF_W-1:0];
  assign busy_o     = (st_q != SEQ_IDLE);
  assign mem_we_o   = (st_q == SEQ_SWEEP) && mask_i[rd_off_o];
  assign mem_addr_o = {page_q, rd_off_o};
  assign mem_data_o = rd_data_i;
endmodule

// File: rtl/page_commit_buf.sv
module page_commit_buf
  import pcb_pkg::*;
#(
  parameter int unsigned ADDR_W      = ADDR_W_DEF,
  parameter int unsigned OFF_W       = OFF_W_DEF,
  parameter int unsigned DATA_W      = DATA_W_DEF,
  parameter int unsigned WCYC_CYCLES = 250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              rd_step_i,
  input  logic              commit_i,
  input  logic              abort_i,
  input  logic              wp_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o
);
  localparam int unsigned NB = 1 << OFF_W;

  logic              idle, load_eff, byte_eff, step_eff, abort_eff;
  logic              commit_eff, start, discard, done, any_staged;
  logic [ADDR_W-1:0] cur_addr, eff_addr;
  logic [NB-1:0]     mask;
  logic [OFF_W-1:0]  rd_off;
  logic [DATA_W-1:0] rd_data;

  assign idle       = !busy_o;
  assign abort_eff  = idle && abort_i;
  assign load_eff   = idle && addr_load_i;
  assign byte_eff   = idle && byte_vld_i && !abort_i;
  assign step_eff   = idle && rd_step_i && !byte_eff;
  assign commit_eff = idle && commit_i && !abort_i;
  assign eff_addr   = load_eff ? addr_i : cur_addr;
  assign any_staged = (|mask) || byte_eff;
  assign start      = commit_eff && !wp_i && any_staged;
  assign discard    = commit_eff && wp_i;

  pcb_addr_ctr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_eff),
    .addr_i     (addr_i),
    .off_inc_i  (byte_eff),
    .full_inc_i (step_eff),
    .addr_o     (cur_addr)
  );

  pcb_page_buf #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (byte_eff),
    .wr_off_i  (eff_addr[OFF_W-1:0]),
    .wr_data_i (byte_i),
    .clr_i     (abort_eff || discard || done),
    .rd_off_i  (rd_off),
    .rd_data_o (rd_data),
    .mask_o    (mask)
  );

  pcb_commit_seq #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .WCYC_CYCLES(WCYC_CYCLES)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .page_i     (eff_addr[ADDR_W-1:OFF_W]),
    .mask_i     (mask),
    .rd_data_i  (rd_data),
    .rd_off_o   (rd_off),
    .busy_o     (busy_o),
    .done_o     (done),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_data_o (mem_data_o)
  );

  assign addr_o = cur_addr;
endmodule

// File: rtl/pcb_chk.sv
module pcb_chk #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned OFF_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              addr_load_i,
  input logic              byte_vld_i,
  input logic              rd_step_i,
  input logic              commit_i,
  input logic              abort_i,
  input logic              wp_i,
  input logic              busy_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              mem_we_o
);
  // R7
  we_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);

  // R8
  wp_no_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && commit_i && wp_i) |=> !busy_o);

  // R11
  busy_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(addr_o));

  // R3
  off_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && byte_vld_i && !abort_i && !addr_load_i) |=>
      (addr_o[ADDR_W-1:OFF_W] == $past(addr_o[ADDR_W-1:OFF_W])) &&
      (addr_o[OFF_W-1:0] == OFF_W'($past(addr_o[OFF_W-1:0]) + 1'b1)));

  // R4
  full_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && rd_step_i && !byte_vld_i && !addr_load_i) |=>
      (addr_o == ADDR_W'($past(addr_o) + 1'b1)));
endmodule

bind page_commit_buf pcb_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_pcb_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_load_i (addr_load_i),
  .byte_vld_i  (byte_vld_i),
  .rd_step_i   (rd_step_i),
  .commit_i    (commit_i),
  .abort_i     (abort_i),
  .wp_i        (wp_i),
  .busy_o      (busy_o),
  .addr_o      (addr_o),
  .mem_we_o    (mem_we_o)
);

// File: tb/page_commit_buf_tb_top.sv
`timescale 1ns/1ps
module page_commit_buf_tb_top;
  localparam int WCYC = 80;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        addr_load_i = 0, byte_vld_i = 0, rd_step_i = 0;
  logic        commit_i = 0, abort_i = 0, wp_i = 0;
  logic [14:0] addr_i = '0;
  logic [7:0]  byte_i = '0;
  logic        busy_o, mem_we_o;
  logic [14:0] addr_o, mem_addr_o;
  logic [7:0]  mem_data_o;

  int checks = 0, errors = 0;
  int nwr = 0, busy_cnt = 0;
  logic [14:0] wr_a [0:255];
  logic [7:0]  wr_d [0:255];

  always #10 clk_i = ~clk_i;

  page_commit_buf #(.WCYC_CYCLES(WCYC)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_load_i(addr_load_i), .addr_i(addr_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .rd_step_i(rd_step_i),
    .commit_i(commit_i), .abort_i(abort_i), .wp_i(wp_i), .busy_o(busy_o),
    .addr_o(addr_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_data_o(mem_data_o)
  );

  always @(negedge clk_i) begin
    if (rst_ni && mem_we_o && nwr < 256) begin
      wr_a[nwr] = mem_addr_o;
      wr_d[nwr] = mem_data_o;
      nwr++;
    end
    if (rst_ni && busy_o) busy_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_log();
    nwr = 0;
    busy_cnt = 0;
  endtask

  task automatic load(input logic [14:0] a);
    @(negedge clk_i); addr_load_i = 1; addr_i = a;
    @(negedge clk_i); addr_load_i = 0;
  endtask

  task automatic put(input logic [7:0] d);
    @(negedge clk_i); byte_vld_i = 1; byte_i = d;
    @(negedge clk_i); byte_vld_i = 0;
  endtask

  task automatic step();
    @(negedge clk_i); rd_step_i = 1;
    @(negedge clk_i); rd_step_i = 0;
  endtask

  task automatic abort_pulse();
    @(negedge clk_i); abort_i = 1;
    @(negedge clk_i); abort_i = 0;
  endtask

  task automatic commit_wait();
    clr_log();
    @(negedge clk_i); commit_i = 1;
    @(negedge clk_i); commit_i = 0;
    repeat (WCYC + 4) @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk(addr_o == 0, "R1 addr", addr_o, 0);
    chk(!busy_o, "R1 busy", busy_o, 0);
    chk(!mem_we_o, "R1 we", mem_we_o, 0);
  endtask

  task automatic t_load_step();
    load(15'h1234);
    chk(addr_o == 15'h1234, "R2 load", addr_o, 15'h1234);
    load(15'h7FFE);
    step();
    chk(addr_o == 15'h7FFF, "R4 step", addr_o, 15'h7FFF);
    step();
    chk(addr_o == 15'h0000, "R4 wrap", addr_o, 0);
  endtask

  task automatic t_off_wrap();
    load({9'd5, 6'd62});
    put(8'h11); put(8'h22); put(8'h33);
    chk(addr_o == {9'd5, 6'd1}, "R3 offset wrap", addr_o, {9'd5, 6'd1});
    abort_pulse();
  endtask

  task automatic t_full_page();
    bit ok;
    load({9'd9, 6'd32});
    for (int i = 0; i < 64; i++) put(8'(8'h40 + i));
    chk(addr_o == {9'd9, 6'd32}, "R5 end offset", addr_o, {9'd9, 6'd32});
    commit_wait();
    chk(nwr == 64, "R5 write count", nwr, 64);
    ok = 1;
    for (int k = 0; k < 64; k++)
      if (wr_a[k] != {9'd9, 6'(k)} || wr_d[k] != 8'(8'h40 + ((k - 32) & 63))) ok = 0;
    chk(ok, "R5 data order", 0, 1);
    chk(busy_cnt == WCYC, "R7 busy length", busy_cnt, WCYC);
  endtask

  task automatic t_overwrite();
    load({9'd3, 6'd60});
    for (int i = 0; i < 66; i++) put(8'(i));
    commit_wait();
    chk(nwr == 64, "R6 count", nwr, 64);
    chk(wr_d[60] == 8'd64, "R6 off60", wr_d[60], 64);
    chk(wr_d[61] == 8'd65, "R6 off61", wr_d[61], 65);
    chk(wr_d[62] == 8'd2, "R6 off62", wr_d[62], 2);
  endtask

  task automatic t_sparse();
    load({9'h1FF, 6'd10});
    put(8'hA0); put(8'hA1); put(8'hA2);
    load({9'h1FF, 6'd40});
    put(8'hB0);
    commit_wait();
    chk(nwr == 4, "R7 count", nwr, 4);
    chk(wr_a[0] == {9'h1FF, 6'd10} && wr_d[0] == 8'hA0, "R7 first", wr_a[0], {9'h1FF, 6'd10});
    chk(wr_a[2] == {9'h1FF, 6'd12} && wr_d[2] == 8'hA2, "R7 third", wr_a[2], {9'h1FF, 6'd12});
    chk(wr_a[3] == {9'h1FF, 6'd40} && wr_d[3] == 8'hB0, "R7 last", wr_a[3], {9'h1FF, 6'd40});
    commit_wait();
    chk(nwr == 0 && busy_cnt == 0, "R7 buffer emptied", nwr, 0);
  endtask

  task automatic t_wp();
    load({9'd20, 6'd0});
    put(8'h55); put(8'h66);
    wp_i = 1;
    commit_wait();
    chk(nwr == 0, "R8 no writes", nwr, 0);
    chk(busy_cnt == 0, "R8 no busy", busy_cnt, 0);
    wp_i = 0;
    commit_wait();
    chk(nwr == 0 && busy_cnt == 0, "R8 discarded", nwr, 0);
  endtask

  task automatic t_empty();
    commit_wait();
    chk(nwr == 0 && busy_cnt == 0, "R9 empty commit", busy_cnt, 0);
  endtask

  task automatic t_abort();
    logic [14:0] a0;
    load({9'd30, 6'd4});
    put(8'h77);
    a0 = addr_o;
    @(negedge clk_i); abort_i = 1; byte_vld_i = 1; byte_i = 8'h88;
    @(negedge clk_i); abort_i = 0; byte_vld_i = 0;
    chk(addr_o == a0, "R10 byte dropped", addr_o, a0);
    commit_wait();
    chk(nwr == 0 && busy_cnt == 0, "R10 abort discards", nwr, 0);
  endtask

  task automatic t_busy();
    logic [14:0] a0;
    load({9'd40, 6'd8});
    put(8'hC3);
    a0 = addr_o;
    clr_log();
    @(negedge clk_i); commit_i = 1;
    @(negedge clk_i); commit_i = 0;
    repeat (3) @(negedge clk_i);
    addr_load_i = 1; addr_i = 15'h0ABC;
    @(negedge clk_i); addr_load_i = 0; byte_vld_i = 1; byte_i = 8'hEE;
    @(negedge clk_i); byte_vld_i = 0; rd_step_i = 1;
    @(negedge clk_i); rd_step_i = 0; abort_i = 1; commit_i = 1;
    @(negedge clk_i); abort_i = 0; commit_i = 0;
    chk(busy_o, "R11 still busy", busy_o, 1);
    repeat (WCYC + 4) @(negedge clk_i);
    chk(addr_o == a0, "R11 addr held", addr_o, a0);
    chk(nwr == 1 && wr_d[0] == 8'hC3, "R11 abort ignored", nwr, 1);
    commit_wait();
    chk(nwr == 0, "R11 byte not staged", nwr, 0);
  endtask

  task automatic t_same_cycle();
    load({9'd50, 6'd5});
    put(8'hD1);
    clr_log();
    @(negedge clk_i); commit_i = 1; byte_vld_i = 1; byte_i = 8'hD2;
    @(negedge clk_i); commit_i = 0; byte_vld_i = 0;
    repeat (WCYC + 4) @(negedge clk_i);
    chk(nwr == 2, "R12 count", nwr, 2);
    chk(wr_a[1] == {9'd50, 6'd6} && wr_d[1] == 8'hD2, "R12 extra byte", wr_d[1], 8'hD2);
    @(negedge clk_i); addr_load_i = 1; addr_i = {9'd7, 6'd20}; byte_vld_i = 1; byte_i = 8'hE4;
    @(negedge clk_i); addr_load_i = 0; byte_vld_i = 0;
    chk(addr_o == {9'd7, 6'd21}, "R13 addr", addr_o, {9'd7, 6'd21});
    commit_wait();
    chk(nwr == 1 && wr_a[0] == {9'd7, 6'd20} && wr_d[0] == 8'hE4, "R13 write", wr_a[0], {9'd7, 6'd20});
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_load_step();
    t_off_wrap();
    t_full_page();
    t_overwrite();
    t_sparse();
    t_wp();
    t_empty();
    t_abort();
    t_busy();
    t_same_cycle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule